// File: doc/BRIEF.md
# Logical Compare Flag Unit

This unit executes an already decoded logical-compare operation from a byte-coded instruction set. The caller presents the primary opcode byte, the 3-bit extension field of the operand-descriptor byte, three prefix indicators (operand-size override, 64-bit widening and bus lock), two fetched operand values, a 32-bit immediate and the incoming auxiliary-carry flag. The unit checks that the form is legal and picks the operand width. It ANDs the first operand with either the second operand or the extended immediate, and derives the status flags. The AND result itself is never driven out, and no operand is ever written back.

Results appear one clock after a single-cycle input valid pulse, together with an output valid. The stream has no back-pressure. The unit accepts a new operation on every cycle that `in_valid` is high, and each result is shown for exactly one cycle. The consumer must take the result in that cycle. A locked form raises a lock fault, and an unknown form raises an unsupported-opcode indication. In both cases the flag outputs keep their previous values.

Top module: `lcmp_flag_unit`

## Requirements
- R1: The unit ANDs the two selected operands and masks the result to the selected width. `zero_flag` is 1 exactly when that masked result is all zeros. Operand bits above the selected width have no effect.
- R2: `sign_flag` equals the top bit of the masked result at the selected width, which is bit 7, 15, 31 or 63.
- R3: `parity_flag` is 1 when bits 7..0 of the result contain an even number of ones. This holds at every operand width.
- R4: `carry_flag` and `ovf_flag` are always 0. On every accepted result, `aux_flag` takes the value of `aux_in`.
- R5: Opcodes 0xA8 and 0xA9 AND `opnd_a` (the accumulator) with the immediate. Opcodes 0xF6 and 0xF7 with `ext_field` = 0 AND `opnd_a` with the immediate. Opcodes 0x84 and 0x85 AND `opnd_a` with `opnd_b`.
- R6: Opcodes 0xA8, 0xF6 and 0x84 operate on 8 bits. For 0xA9, 0xF7 and 0x85, `pfx_wide` selects 64 bits. Otherwise `pfx_opsize` selects 16 bits, and with neither prefix the width is 32 bits. Widening wins over the size override.
- R7: Immediate forms use `imm[7:0]` at 8 bits, `imm[15:0]` at 16 bits and `imm[31:0]` at 32 bits. At 64 bits, `imm[31:0]` is sign-extended to 64 bits.
- R8: A legal form with `pfx_lock` = 1 sets `lock_fault` with its result, clears `bad_opcode`, and leaves all flag outputs unchanged.
- R9: Opcode 0xF6 or 0xF7 with `ext_field` ≠ 0, and any opcode outside the six listed, sets `bad_opcode` and clears `lock_fault`, whether or not `pfx_lock` is set. All flag outputs stay unchanged.
- R10: `out_valid` is high in the cycle after each cycle with `in_valid` high, and low otherwise. `lock_fault` and `bad_opcode` are only ever high together with `out_valid`. Flags change only on an accepted result.
- R11: Synchronous active-high reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| opcode | input | 8 | Primary opcode byte |
| ext_field | input | 3 | Extension field of the operand-descriptor byte |
| pfx_opsize | input | 1 | Operand-size override prefix present |
| pfx_wide | input | 1 | 64-bit widening prefix present |
| pfx_lock | input | 1 | Lock prefix present |
| opnd_a | input | 64 | First operand (accumulator or register/memory value) |
| opnd_b | input | 64 | Second operand for register forms |
| imm | input | 32 | Immediate value |
| aux_in | input | 1 | Current auxiliary-carry flag, carried through |
| out_valid | output | 1 | Result present this cycle |
| zero_flag | output | 1 | Zero flag |
| sign_flag | output | 1 | Sign flag |
| parity_flag | output | 1 | Even parity of the low result byte |
| carry_flag | output | 1 | Carry flag, always 0 |
| ovf_flag | output | 1 | Overflow flag, always 0 |
| aux_flag | output | 1 | Auxiliary-carry flag |
| lock_fault | output | 1 | Invalid-opcode fault due to the lock prefix |
| bad_opcode | output | 1 | Form not supported by this unit |

## Verification
The bench builds the unit with its default parameters: 64-bit operands and a 32-bit immediate. With these values all four width lanes exist. The 64-bit sign-extension of the immediate can therefore be told apart from zero-extension, and operand bits above a narrow width can be set to show that they have no effect. Back-to-back pulses, faults sandwiched between good results, and a reset in the middle of the stream cover the hold and latency rules.

// File: rtl/lcmp_pkg.sv
package lcmp_pkg;
  localparam int DATA_W  = 64;
  localparam int IMM_W   = 32;
  localparam int NUM_WID = 4;

  localparam logic [7:0] OP_ACC_B = 8'hA8;
  localparam logic [7:0] OP_ACC_W = 8'hA9;
  localparam logic [7:0] OP_GRP_B = 8'hF6;
  localparam logic [7:0] OP_GRP_W = 8'hF7;
  localparam logic [7:0] OP_RR_B  = 8'h84;
  localparam logic [7:0] OP_RR_W  = 8'h85;

  typedef enum logic [1:0] {WID_8, WID_16, WID_32, WID_64} width_e;
  typedef enum logic {SRC_IMM, SRC_REG} src_e;

  typedef struct packed {
    logic   legal;
    logic   unsupported;
    width_e width;
    src_e   src;
  } dec_t;

  typedef struct packed {
    logic zf;
    logic sf;
    logic pf;
  } flags_t;
endpackage

// File: rtl/lcmp_decode.sv
module lcmp_decode
  import lcmp_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [2:0] ext_field,
  input  logic       pfx_opsize,
  input  logic       pfx_wide,
  output dec_t       dec
);
  logic known;
  logic byte_form;
  logic use_imm;

  always_comb begin
    known     = 1'b0;
    byte_form = 1'b0;
    use_imm   = 1'b0;
    case (opcode)
      OP_ACC_B: begin known = 1'b1; byte_form = 1'b1; use_imm = 1'b1; end
      OP_ACC_W: begin known = 1'b1; use_imm = 1'b1; end
      OP_GRP_B: begin known = (ext_field == 3'd0); byte_form = 1'b1; use_imm = 1'b1; end
      OP_GRP_W: begin known = (ext_field == 3'd0); use_imm = 1'b1; end
      OP_RR_B:  begin known = 1'b1; byte_form = 1'b1; end
      OP_RR_W:  begin known = 1'b1; end
      default:  begin known = 1'b0; end
    endcase
  end

  always_comb begin
    dec.legal       = known;
    dec.unsupported = ~known;
    dec.src         = use_imm ? SRC_IMM : SRC_REG;
    if (byte_form)       dec.width = WID_8;
    else if (pfx_wide)   dec.width = WID_64;
    else if (pfx_opsize) dec.width = WID_16;
    else                 dec.width = WID_32;
  end
endmodule

// File: rtl/lcmp_operand_sel.sv
module lcmp_operand_sel
  import lcmp_pkg::*;
#(
  parameter int DATA_W = lcmp_pkg::DATA_W,
  parameter int IMM_W  = lcmp_pkg::IMM_W
) (
  input  width_e            width,
  input  src_e              src,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] second
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  always_comb begin
    case (width)
      WID_8:   imm_ext = {{(DATA_W-8){1'b0}}, imm[7:0]};
      WID_16:  imm_ext = {{(DATA_W-16){1'b0}}, imm[15:0]};
      WID_32:  imm_ext = {{EXT_W{1'b0}}, imm};
      default: imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
    endcase
    second = (src == SRC_IMM) ? imm_ext : opnd_b;
  end
endmodule

// File: rtl/lcmp_flags.sv
module lcmp_flags
  import lcmp_pkg::*;
#(
  parameter int DATA_W = lcmp_pkg::DATA_W
) (
  input  logic [DATA_W-1:0] res,
  input  width_e            width,
  output flags_t            fl
);
  logic [NUM_WID-1:0] zero_w;
  logic [NUM_WID-1:0] sign_w;

  for (genvar g = 0; g < NUM_WID; g++) begin : g_lane
    localparam int LW = 8 << g;
    assign zero_w[g] = ~|res[LW-1:0];
    assign sign_w[g] = res[LW-1];
  end

  assign fl.zf = zero_w[width];
  assign fl.sf = sign_w[width];
  assign fl.pf = ~^res[7:0];
endmodule

// File: rtl/lcmp_flag_unit.sv
module lcmp_flag_unit
  import lcmp_pkg::*;
#(
  parameter int DATA_W = lcmp_pkg::DATA_W,
  parameter int IMM_W  = lcmp_pkg::IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        opcode,
  input  logic [2:0]        ext_field,
  input  logic              pfx_opsize,
  input  logic              pfx_wide,
  input  logic              pfx_lock,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              aux_in,
  output logic              out_valid,
  output logic              zero_flag,
  output logic              sign_flag,
  output logic              parity_flag,
  output logic              carry_flag,
  output logic              ovf_flag,
  output logic              aux_flag,
  output logic              lock_fault,
  output logic              bad_opcode
);
  dec_t              dec;
  logic [DATA_W-1:0] second;
  logic [DATA_W-1:0] and_res;
  flags_t            fl;
  logic              commit;

  lcmp_decode u_dec (
    .opcode     (opcode),
    .ext_field  (ext_field),
    .pfx_opsize (pfx_opsize),
    .pfx_wide   (pfx_wide),
    .dec        (dec)
  );

  lcmp_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .width  (dec.width),
    .src    (dec.src),
    .opnd_b (opnd_b),
    .imm    (imm),
    .second (second)
  );

  assign and_res = opnd_a & second;

  lcmp_flags #(.DATA_W(DATA_W)) u_flags (
    .res   (and_res),
    .width (dec.width),
    .fl    (fl)
  );

  assign commit = in_valid & dec.legal & ~pfx_lock;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      lock_fault  <= 1'b0;
      bad_opcode  <= 1'b0;
      zero_flag   <= 1'b0;
      sign_flag   <= 1'b0;
      parity_flag <= 1'b0;
      aux_flag    <= 1'b0;
    end else begin
      out_valid  <= in_valid;
      lock_fault <= in_valid & dec.legal & pfx_lock;
      bad_opcode <= in_valid & dec.unsupported;
      if (commit) begin
        zero_flag   <= fl.zf;
        sign_flag   <= fl.sf;
        parity_flag <= fl.pf;
        aux_flag    <= aux_in;
      end
    end
  end

  assign carry_flag = 1'b0;
  assign ovf_flag   = 1'b0;
endmodule

// File: rtl/lcmp_flag_unit_chk.sv
module lcmp_flag_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic [7:0] opcode,
  input logic [2:0] ext_field,
  input logic       pfx_lock,
  input logic       out_valid,
  input logic       zero_flag,
  input logic       sign_flag,
  input logic       parity_flag,
  input logic       aux_flag,
  input logic       lock_fault,
  input logic       bad_opcode
);
  logic [3:0] flag_vec;
  assign flag_vec = {zero_flag, sign_flag, parity_flag, aux_flag};

  p_valid_follows_r10: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_no_spurious_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_fault_with_valid_r10: assert property (@(posedge clk) disable iff (rst)
    (lock_fault || bad_opcode) |-> out_valid);
  p_quiet_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(flag_vec));
  p_lock_raises_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pfx_lock && (opcode == 8'h85 || opcode == 8'h84)) |=> (lock_fault && !bad_opcode));
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (rst)
    lock_fault |-> $stable(flag_vec));
  p_bad_ext_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (opcode == 8'hF6 || opcode == 8'hF7) && ext_field != 3'd0) |=> (bad_opcode && !lock_fault));
  p_bad_holds_r9: assert property (@(posedge clk) disable iff (rst)
    bad_opcode |-> $stable(flag_vec));
  p_zero_even_r3: assert property (@(posedge clk) disable iff (rst)
    zero_flag |-> parity_flag);
  p_zero_positive_r2: assert property (@(posedge clk) disable iff (rst)
    zero_flag |-> !sign_flag);
  p_reset_clears_r11: assert property (@(posedge clk)
    rst |=> (!out_valid && !lock_fault && !bad_opcode && flag_vec == 4'd0));
endmodule

bind lcmp_flag_unit lcmp_flag_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .opcode      (opcode),
  .ext_field   (ext_field),
  .pfx_lock    (pfx_lock),
  .out_valid   (out_valid),
  .zero_flag   (zero_flag),
  .sign_flag   (sign_flag),
  .parity_flag (parity_flag),
  .aux_flag    (aux_flag),
  .lock_fault  (lock_fault),
  .bad_opcode  (bad_opcode)
);

// File: tb/tb_lcmp_flag_unit.sv
module tb_lcmp_flag_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [2:0]  ext_field = 3'd0;
  logic        pfx_opsize = 1'b0, pfx_wide = 1'b0, pfx_lock = 1'b0;
  logic [63:0] opnd_a = '0, opnd_b = '0;
  logic [31:0] imm = '0;
  logic        aux_in = 1'b0;
  logic        out_valid, zero_flag, sign_flag, parity_flag;
  logic        carry_flag, ovf_flag, aux_flag, lock_fault, bad_opcode;

  always #4 clk = ~clk;

  lcmp_flag_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opcode(opcode), .ext_field(ext_field),
    .pfx_opsize(pfx_opsize), .pfx_wide(pfx_wide), .pfx_lock(pfx_lock),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .aux_in(aux_in),
    .out_valid(out_valid), .zero_flag(zero_flag), .sign_flag(sign_flag),
    .parity_flag(parity_flag), .carry_flag(carry_flag), .ovf_flag(ovf_flag),
    .aux_flag(aux_flag), .lock_fault(lock_fault), .bad_opcode(bad_opcode)
  );

  typedef struct {
    string tag;
    logic  lk, bad, z, s, p, a;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  logic mz = 1'b0, ms = 1'b0, mp = 1'b0, ma = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic send(input string tag, input logic [7:0] op, input logic [2:0] ext,
                      input bit osz, input bit wide, input bit lock,
                      input logic [63:0] a, input logic [63:0] b,
                      input logic [31:0] im, input bit aux);
    bit known, byte_f, use_imm;
    int w;
    logic [63:0] sec, r, mask;
    exp_t e;
    byte_f  = op inside {8'hA8, 8'hF6, 8'h84};
    use_imm = op inside {8'hA8, 8'hA9, 8'hF6, 8'hF7};
    known   = op inside {8'hA8, 8'hA9, 8'h84, 8'h85} ||
              ((op inside {8'hF6, 8'hF7}) && ext == 3'd0);
    w = byte_f ? 8 : wide ? 64 : osz ? 16 : 32;
    mask = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    sec  = use_imm ? ((w == 64) ? {{32{im[31]}}, im} : {32'd0, im}) : b;
    r    = a & sec & mask;
    if (known && !lock) begin
      mz = (r == 64'd0);
      ms = r[w-1];
      mp = ~^r[7:0];
      ma = aux;
    end
    e.tag = tag; e.lk = known && lock; e.bad = !known;
    e.z = mz; e.s = ms; e.p = mp; e.a = ma;
    in_valid = 1'b1; opcode = op; ext_field = ext; pfx_opsize = osz; pfx_wide = wide;
    pfx_lock = lock; opnd_a = a; opnd_b = b; imm = im; aux_in = aux;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_all_zero(input string tag);
    check({out_valid, zero_flag, sign_flag, parity_flag, carry_flag, ovf_flag,
           aux_flag, lock_fault, bad_opcode} == 9'd0, tag, "outputs after reset",
          {out_valid, zero_flag, sign_flag, parity_flag, carry_flag, ovf_flag,
           aux_flag, lock_fault, bad_opcode}, 64'd0);
  endtask

  // Monitor: compares each produced result against the queue head.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst) begin
        if (out_valid) begin
          if (q.size() == 0) begin
            check(1'b0, "R10", "out_valid without request", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check(lock_fault == e.lk, e.tag, "lock_fault", lock_fault, e.lk);
            check(bad_opcode == e.bad, e.tag, "bad_opcode", bad_opcode, e.bad);
            check(zero_flag == e.z, e.tag, "zero_flag", zero_flag, e.z);
            check(sign_flag == e.s, e.tag, "sign_flag", sign_flag, e.s);
            check(parity_flag == e.p, e.tag, "parity_flag", parity_flag, e.p);
            check(aux_flag == e.a, e.tag, "aux_flag", aux_flag, e.a);
            check({carry_flag, ovf_flag} == 2'b00, "R4", "carry/ovf", {carry_flag, ovf_flag}, 0);
          end
        end else begin
          if (q.size() != 0) begin
            void'(q.pop_front());
            check(1'b0, "R10", "missing out_valid", 0, 1);
          end
          check({lock_fault, bad_opcode} == 2'b00, "R10", "fault without valid",
                {lock_fault, bad_opcode}, 0);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  initial begin
    // R11: reset holds outputs clear even with a request present.
    @(negedge clk);
    in_valid = 1'b1; opcode = 8'h84; opnd_a = '1; opnd_b = '1; aux_in = 1'b1;
    idle(2);
    check_all_zero("R11");
    in_valid = 1'b0;
    rst = 1'b0;
    idle(2);

    send("R2",  8'h84, 3'd0, 0, 0, 0, 64'hFFFF_FF80, 64'h80, 32'h0, 0);
    send("R1",  8'h85, 3'd0, 0, 0, 0, 64'hFFFF_FFFF_0000_0000, '1, 32'h0, 0);
    send("R6",  8'h85, 3'd0, 0, 1, 0, 64'hFFFF_FFFF_0000_0000, '1, 32'h0, 0);
    send("R6",  8'h85, 3'd0, 1, 0, 0, 64'h0001_8000, 64'hFFFF_FFFF, 32'h0, 0);
    send("R6",  8'h85, 3'd0, 1, 1, 0, 64'h0000_0100_0000_0000, 64'h0000_0100_0000_0000, 32'h0, 0);
    idle(1);
    send("R5",  8'hA8, 3'd5, 0, 0, 0, 64'h07, 64'h0, 32'hFFFF_FF03, 0);
    send("R7",  8'hA9, 3'd0, 0, 1, 0, 64'h8000_0000_0000_0000, 64'h0, 32'h8000_0000, 0);
    send("R7",  8'hA9, 3'd0, 1, 0, 0, 64'h1234_FF0F, 64'h0, 32'hFFFF_00F0, 0);
    send("R5",  8'hF7, 3'd0, 0, 0, 0, 64'h1, '1, 32'hFFFF_FFFF, 0);
    send("R3",  8'hF6, 3'd0, 0, 0, 0, 64'h7F, '1, 32'hFF, 1);
    send("R4",  8'h84, 3'd0, 0, 0, 0, 64'h01, 64'h01, 32'h0, 1);
    idle(2);
    send("R9",  8'hF7, 3'd3, 0, 0, 0, '0, '0, 32'h0, 0);
    send("R9",  8'h86, 3'd0, 0, 0, 0, '0, '0, 32'h0, 0);
    send("R9",  8'hF6, 3'd7, 0, 0, 1, '0, '0, 32'h0, 0);
    send("R8",  8'h85, 3'd0, 0, 0, 1, '0, '0, 32'h0, 0);
    send("R8",  8'hA8, 3'd0, 0, 0, 1, '0, '0, 32'h0, 0);
    send("R3",  8'h85, 3'd0, 0, 1, 0, 64'hF000_0000_0000_0003, '1, 32'h0, 0);
    send("R3",  8'h85, 3'd0, 1, 0, 0, 64'h0000_FF01, '1, 32'h0, 0);
    send("R10", 8'hA9, 3'd0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h0000_0080, 0);
    idle(3);
    // R11: reset in the middle of the stream clears flags.
    rst = 1'b1;
    idle(2);
    check_all_zero("R11");
    mz = 1'b0; ms = 1'b0; mp = 1'b0; ma = 1'b0;
    rst = 1'b0;
    idle(1);
    send("R9",  8'h00, 3'd0, 0, 0, 0, '1, '1, 32'hFFFF_FFFF, 1);
    send("R1",  8'hF7, 3'd0, 0, 0, 0, 64'hFFFF_FFFF_0000_0000, 64'h0, 32'hFFFF_FFFF, 0);
    idle(3);
    summary();
  end
endmodule